// File: doc/BRIEF.md
# Two-Stage Separable Switch Allocator

This block decides, once per clock, which flits cross a router's crossbar. The router has a number of input ports, and each input port buffers several virtual channels (VCs). Because every input port drives only one crossbar input, at most one of its VCs can move a flit in any cycle. The allocator settles this in two stages. In the first stage, each input port chooses one of its eligible VCs by round robin. In the second stage, each output port chooses by round robin among the inputs whose chosen VC targets it.

Each VC presents a request bit, the index of the output its flit wants, and head and tail markers for that flit. When a packet's head flit wins an output and is not also the tail, that output is locked to the winning input and VC. The lock holds until the same VC's tail flit has been granted. Grants are registered. The surrounding router uses them in the cycle after the requests it presented.

Fairness between the two stages is coupled. An input's first-stage pointer moves only when its choice also wins an output. An output's pointer moves only when it starts a new packet.

Top module: `sa_switch_alloc`

## Requirements
- R1: For each input port, at most one bit of that port's slice of `vc_grant_o` is set in any cycle.
- R2: For each output port, at most one input is granted. Each input is granted at most one output. An input has a VC grant exactly when some output grants that input.
- R3: Grants are registered and appear in the cycle after the requests are sampled. A VC is granted only if it was requesting. Its input is granted the output whose binary index was in that VC's destination field.
- R4: At each input, the first stage picks the first eligible VC found by searching upward from the VC pointer and wrapping around.
- R5: An input's VC pointer moves to one past the chosen VC only when that input receives an output grant. A choice that loses in the second stage leaves the pointer unchanged.
- R6: At each unlocked output, the second stage picks the first nominating input found by searching upward from the output pointer and wrapping around. When that new packet is granted, the pointer moves to one past the winner.
- R7: A granted flit with head=1 and tail=0 locks its output to that input and VC. While the output is locked, only that input and VC can be granted it, whatever their head flag. Other requests for that output wait, and the output pointer stays where it is.
- R8: Granting the lock owner a flit with tail=1 releases the lock. A flit with head=1 and tail=1 granted on an unlocked output leaves the output unlocked.
- R9: On an unlocked output, a request with head=0 is not eligible and receives no grant.
- R10: While the synchronous active-low reset is asserted, all grants read zero. Reset clears every lock and sets every pointer to index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid_i | input | NUM_PORTS*NUM_VCS | Request per VC; bit i*NUM_VCS+v is VC v of input i |
| req_dest_i | input | NUM_PORTS*NUM_VCS*PW | Target output index per VC, field (i*NUM_VCS+v)*PW |
| req_head_i | input | NUM_PORTS*NUM_VCS | Flit is the first of its packet |
| req_tail_i | input | NUM_PORTS*NUM_VCS | Flit is the last of its packet |
| vc_grant_o | output | NUM_PORTS*NUM_VCS | Registered VC grant, same bit layout as req_valid_i |
| out_grant_o | output | NUM_PORTS*NUM_PORTS | Registered output grant; bit o*NUM_PORTS+i means output o goes to input i |

## Verification
The bench goes after the point where the two stages meet. In one case, an input's choice loses the output contest. A design that advances that input's pointer anyway would pick a different VC in the next cycle, and the bench expects the same VC. The bench holds an output locked while a second VC of the owning input and other inputs request it. A design that compares only the input index, or that moves the output pointer during the lock, hands the output to the wrong requester when it is released. The bench also checks that single-flit packets do not lock their output and that body flits aimed at a free output are ignored. A long pseudo-random sweep is then compared against an arithmetic model of all the pointers and locks.

// File: rtl/sa_pkg.sv
// Shared helpers for the switch allocator.
// Assumes indices are non-negative and smaller than the range n.
package sa_pkg;

    // Index that follows cur in a ring of n positions.
    function automatic int wrap_next(input int cur, input int n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/sa_rr_pick.sv
// Combinational round-robin picker: grants the first set request at or
// above ptr, wrapping past N-1 to 0.
// Assumes ptr < N; produces a one-hot grant plus its binary index.
module sa_rr_pick #(
    parameter int N = 4,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] ptr,
    output logic [N-1:0] gnt,
    output logic         any,
    output logic [W-1:0] idx
);

    int j;

    // Scan the ring starting at the pointer; first hit wins.
    always_comb begin
        gnt = '0;
        any = 1'b0;
        idx = '0;
        j   = 0;
        for (int k = 0; k < N; k++) begin
            j = int'(ptr) + k;
            if (j >= N) j = j - N;
            if (!any && req[j]) begin
                any    = 1'b1;
                idx    = W'(j);
                gnt[j] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sa_vc_stage.sv
// First allocation stage for one input port: filters the port's VCs by
// lock state and head flag, then picks one by round robin.
// Assumes lock state arrives registered from the output stages; the pointer
// moves only when the nominated VC is granted an output (won).
module sa_vc_stage #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_VCS   = 3,
    parameter int MY_PORT   = 0,
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int VW = (NUM_VCS > 1) ? $clog2(NUM_VCS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_VCS-1:0]      req,
    input  logic [NUM_VCS*PW-1:0]   dest,
    input  logic [NUM_VCS-1:0]      head,
    input  logic [NUM_VCS-1:0]      tail,
    input  logic [NUM_PORTS-1:0]    lock_vec,
    input  logic [NUM_PORTS*PW-1:0] lock_port,
    input  logic [NUM_PORTS*VW-1:0] lock_vc,
    input  logic                    won,
    output logic                    nom_valid,
    output logic [VW-1:0]           nom_vc,
    output logic [PW-1:0]           nom_dest,
    output logic                    nom_tail
);

    logic [NUM_VCS-1:0] elig;
    logic [NUM_VCS-1:0] pick_oh;
    logic [VW-1:0]      vptr;
    logic [PW-1:0]      d;

    // Eligibility: locked target must be owned by this VC, free target needs a head flit.
    always_comb begin
        elig = '0;
        d    = '0;
        for (int v = 0; v < NUM_VCS; v++) begin
            d = dest[v*PW +: PW];
            if (req[v] && (int'(d) < NUM_PORTS)) begin
                if (lock_vec[d])
                    elig[v] = (lock_port[int'(d)*PW +: PW] == PW'(MY_PORT)) &&
                              (lock_vc[int'(d)*VW +: VW] == VW'(v));
                else
                    elig[v] = head[v];
            end
        end
    end

    sa_rr_pick #(.N(NUM_VCS)) u_pick (
        .req (elig),
        .ptr (vptr),
        .gnt (pick_oh),
        .any (nom_valid),
        .idx (nom_vc)
    );

    // Route the nominee's target and tail marker to the output stages.
    always_comb begin
        nom_dest = dest[int'(nom_vc)*PW +: PW];
        nom_tail = tail[nom_vc];
    end

    // Pointer advances past the nominee only when the nominee got an output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vptr <= '0;
        else if (won && nom_valid)
            vptr <= VW'(sa_pkg::wrap_next(int'(nom_vc), NUM_VCS));
    end

endmodule

// File: rtl/sa_out_stage.sv
// Second allocation stage for one output port: round robin among the inputs
// nominating this output, with a packet lock held from head to tail.
// Assumes at most one nomination per input; the pointer moves only when a
// new packet is granted on an unlocked output.
module sa_out_stage #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_VCS   = 3,
    parameter int MY_PORT   = 0,
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int VW = (NUM_VCS > 1) ? $clog2(NUM_VCS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_PORTS-1:0]    nom_valid,
    input  logic [NUM_PORTS*PW-1:0] nom_dest,
    input  logic [NUM_PORTS*VW-1:0] nom_vc,
    input  logic [NUM_PORTS-1:0]    nom_tail,
    output logic [NUM_PORTS-1:0]    gnt,
    output logic                    locked,
    output logic [PW-1:0]           owner_port,
    output logic [VW-1:0]           owner_vc
);

    logic [NUM_PORTS-1:0] cand;
    logic [PW-1:0]        optr;
    logic                 any;
    logic [PW-1:0]        idx;

    // Candidates: inputs aiming here; under a lock only the owner remains.
    always_comb begin
        for (int i = 0; i < NUM_PORTS; i++) begin
            cand[i] = nom_valid[i] &&
                      (nom_dest[i*PW +: PW] == PW'(MY_PORT)) &&
                      (!locked || (owner_port == PW'(i)));
        end
    end

    sa_rr_pick #(.N(NUM_PORTS)) u_pick (
        .req (cand),
        .ptr (optr),
        .gnt (gnt),
        .any (any),
        .idx (idx)
    );

    // Lock bookkeeping and pointer update on each grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked     <= 1'b0;
            owner_port <= '0;
            owner_vc   <= '0;
            optr       <= '0;
        end else if (any) begin
            if (locked) begin
                if (nom_tail[idx]) locked <= 1'b0;
            end else begin
                optr <= PW'(sa_pkg::wrap_next(int'(idx), NUM_PORTS));
                if (!nom_tail[idx]) begin
                    locked     <= 1'b1;
                    owner_port <= idx;
                    owner_vc   <= nom_vc[int'(idx)*VW +: VW];
                end
            end
        end
    end

endmodule

// File: rtl/sa_switch_alloc.sv
// Two-stage separable switch allocator: one VC stage per input port feeds
// one output stage per output port; grants are registered.
// Assumes req_dest_i fields hold binary output indices; the requester uses
// the grants in the cycle after it presented the requests.
module sa_switch_alloc #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_VCS   = 3,
    localparam int PW  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int VW  = (NUM_VCS > 1) ? $clog2(NUM_VCS) : 1,
    localparam int NPV = NUM_PORTS * NUM_VCS,
    localparam int NPP = NUM_PORTS * NUM_PORTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPV-1:0]    req_valid_i,
    input  logic [NPV*PW-1:0] req_dest_i,
    input  logic [NPV-1:0]    req_head_i,
    input  logic [NPV-1:0]    req_tail_i,
    output logic [NPV-1:0]    vc_grant_o,
    output logic [NPP-1:0]    out_grant_o
);

    logic [NUM_PORTS-1:0]    nom_valid;
    logic [NUM_PORTS*PW-1:0] nom_dest;
    logic [NUM_PORTS*VW-1:0] nom_vc;
    logic [NUM_PORTS-1:0]    nom_tail;
    logic [NUM_PORTS-1:0]    lock_vec;
    logic [NUM_PORTS*PW-1:0] lock_port;
    logic [NUM_PORTS*VW-1:0] lock_vc;
    logic [NPP-1:0]          gnt_now;
    logic [NUM_PORTS-1:0]    won;
    logic [NPV-1:0]          vc_next;

    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_in
        sa_vc_stage #(
            .NUM_PORTS (NUM_PORTS),
            .NUM_VCS   (NUM_VCS),
            .MY_PORT   (gi)
        ) u_vc (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req_valid_i[gi*NUM_VCS +: NUM_VCS]),
            .dest      (req_dest_i[gi*NUM_VCS*PW +: NUM_VCS*PW]),
            .head      (req_head_i[gi*NUM_VCS +: NUM_VCS]),
            .tail      (req_tail_i[gi*NUM_VCS +: NUM_VCS]),
            .lock_vec  (lock_vec),
            .lock_port (lock_port),
            .lock_vc   (lock_vc),
            .won       (won[gi]),
            .nom_valid (nom_valid[gi]),
            .nom_vc    (nom_vc[gi*VW +: VW]),
            .nom_dest  (nom_dest[gi*PW +: PW]),
            .nom_tail  (nom_tail[gi])
        );
    end

    for (genvar go = 0; go < NUM_PORTS; go++) begin : g_out
        sa_out_stage #(
            .NUM_PORTS (NUM_PORTS),
            .NUM_VCS   (NUM_VCS),
            .MY_PORT   (go)
        ) u_out (
            .clk        (clk),
            .rst_n      (rst_n),
            .nom_valid  (nom_valid),
            .nom_dest   (nom_dest),
            .nom_vc     (nom_vc),
            .nom_tail   (nom_tail),
            .gnt        (gnt_now[go*NUM_PORTS +: NUM_PORTS]),
            .locked     (lock_vec[go]),
            .owner_port (lock_port[go*PW +: PW]),
            .owner_vc   (lock_vc[go*VW +: VW])
        );
    end

    // Feed second-stage outcome back to each input and form the VC grant.
    always_comb begin
        won     = '0;
        vc_next = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            for (int o = 0; o < NUM_PORTS; o++)
                won[i] = won[i] | gnt_now[o*NUM_PORTS + i];
            for (int v = 0; v < NUM_VCS; v++)
                vc_next[i*NUM_VCS + v] = won[i] && (nom_vc[i*VW +: VW] == VW'(v));
        end
    end

    // Register the grants toward the datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vc_grant_o  <= '0;
            out_grant_o <= '0;
        end else begin
            vc_grant_o  <= vc_next;
            out_grant_o <= gnt_now;
        end
    end

endmodule

// File: rtl/sa_switch_alloc_chk.sv
// Property checker for sa_switch_alloc, attached through bind.
// Assumes it sees only the allocator's ports.
module sa_switch_alloc_chk #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_VCS   = 3,
    localparam int NPV = NUM_PORTS * NUM_VCS,
    localparam int NPP = NUM_PORTS * NUM_PORTS
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NPV-1:0] req_valid_i,
    input logic [NPV-1:0] vc_grant_o,
    input logic [NPP-1:0] out_grant_o
);

    logic [NUM_PORTS-1:0] in_sel;
    logic [NUM_PORTS-1:0] col [NUM_PORTS];

    // Gather, per input, which outputs currently grant it.
    always_comb begin
        for (int i = 0; i < NUM_PORTS; i++) begin
            for (int o = 0; o < NUM_PORTS; o++)
                col[i][o] = out_grant_o[o*NUM_PORTS + i];
            in_sel[i] = |col[i];
        end
    end

    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_in
        a_r1_vc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(vc_grant_o[gi*NUM_VCS +: NUM_VCS]));
        a_r2_one_output_per_input: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col[gi]));
        a_r2_vc_matches_output: assert property (@(posedge clk) disable iff (!rst_n)
            (|vc_grant_o[gi*NUM_VCS +: NUM_VCS]) == in_sel[gi]);
    end

    for (genvar go = 0; go < NUM_PORTS; go++) begin : g_out
        a_r2_out_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(out_grant_o[go*NUM_PORTS +: NUM_PORTS]));
    end

    for (genvar gb = 0; gb < NPV; gb++) begin : g_vc
        a_r3_grant_was_requested: assert property (@(posedge clk) disable iff (!rst_n)
            vc_grant_o[gb] |-> $past(req_valid_i[gb]));
    end

    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (vc_grant_o == '0 && out_grant_o == '0));

endmodule

bind sa_switch_alloc sa_switch_alloc_chk #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_VCS   (NUM_VCS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .vc_grant_o  (vc_grant_o),
    .out_grant_o (out_grant_o)
);

// File: tb/sa_switch_alloc_test.sv
`timescale 1ns/1ps
module sa_switch_alloc_test;

    localparam int P   = 4;
    localparam int V   = 3;
    localparam int PW  = 2;
    localparam int NPV = P * V;
    localparam int NPP = P * P;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NPV-1:0]    req_valid_i = '0;
    logic [NPV*PW-1:0] req_dest_i = '0;
    logic [NPV-1:0]    req_head_i = '0;
    logic [NPV-1:0]    req_tail_i = '0;
    logic [NPV-1:0]    vc_grant_o;
    logic [NPP-1:0]    out_grant_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_vptr [P];
    int m_optr [P];
    int m_lock [P];
    int m_ownp [P];
    int m_ownv [P];

    sa_switch_alloc #(.NUM_PORTS(P), .NUM_VCS(V)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_dest_i  (req_dest_i),
        .req_head_i  (req_head_i),
        .req_tail_i  (req_tail_i),
        .vc_grant_o  (vc_grant_o),
        .out_grant_o (out_grant_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < P; k++) begin
            m_vptr[k] = 0; m_optr[k] = 0; m_lock[k] = 0; m_ownp[k] = 0; m_ownv[k] = 0;
        end
    endtask

    // Reference: computes one cycle of grants from the requirements and updates state.
    task automatic model(output logic [NPV-1:0] ev, output logic [NPP-1:0] eo);
        int nv [P];
        int nvc [P];
        int nd [P];
        ev = '0;
        eo = '0;
        for (int i = 0; i < P; i++) begin
            nv[i] = 0; nvc[i] = 0; nd[i] = 0;
            for (int k = 0; k < V; k++) begin
                int v, b, d;
                bit el;
                v = (m_vptr[i] + k) % V;
                b = i * V + v;
                d = int'(req_dest_i[b*PW +: PW]);
                el = 1'b0;
                if (req_valid_i[b]) begin
                    if (m_lock[d] != 0) el = (m_ownp[d] == i) && (m_ownv[d] == v);
                    else el = req_head_i[b];
                end
                if (el && nv[i] == 0) begin
                    nv[i] = 1; nvc[i] = v; nd[i] = d;
                end
            end
        end
        for (int o = 0; o < P; o++) begin
            int g;
            g = -1;
            for (int k = 0; k < P; k++) begin
                int i;
                i = (m_optr[o] + k) % P;
                if (g < 0 && nv[i] != 0 && nd[i] == o && (m_lock[o] == 0 || m_ownp[o] == i)) g = i;
            end
            if (g >= 0) begin
                int b;
                b = g * V + nvc[g];
                eo[o*P + g] = 1'b1;
                ev[b] = 1'b1;
                m_vptr[g] = (nvc[g] + 1) % V;
                if (m_lock[o] != 0) begin
                    if (req_tail_i[b]) m_lock[o] = 0;
                end else begin
                    m_optr[o] = (g + 1) % P;
                    if (!req_tail_i[b]) begin
                        m_lock[o] = 1; m_ownp[o] = g; m_ownv[o] = nvc[g];
                    end
                end
            end
        end
    endtask

    // One clock: model, clock edge, sample at the falling edge, compare.
    task automatic step(input string tag);
        logic [NPV-1:0] ev;
        logic [NPP-1:0] eo;
        model(ev, eo);
        @(posedge clk);
        @(negedge clk);
        check(tag, "vc_grant", 64'(vc_grant_o), 64'(ev));
        check(tag, "out_grant", 64'(out_grant_o), 64'(eo));
    endtask

    task automatic set_vc(input int i, input int v, input int d, input bit h, input bit t);
        int b;
        b = i * V + v;
        req_valid_i[b] = 1'b1;
        req_dest_i[b*PW +: PW] = PW'(d);
        req_head_i[b] = h;
        req_tail_i[b] = t;
    endtask

    task automatic clear_all();
        req_valid_i = '0; req_dest_i = '0; req_head_i = '0; req_tail_i = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(100000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        // R10: requests present during reset give no grants.
        for (int v = 0; v < V; v++) set_vc(0, v, 1, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        check("R10", "vc_grant in reset", 64'(vc_grant_o), 64'd0);
        check("R10", "out_grant in reset", 64'(out_grant_o), 64'd0);
        rst_n = 1'b1;

        // R4/R5: three VCs of input 0 take turns from VC0.
        step("R4"); check("R4", "vc order 1", 64'(vc_grant_o[2:0]), 64'b001);
        step("R4"); check("R4", "vc order 2", 64'(vc_grant_o[2:0]), 64'b010);
        step("R4"); check("R4", "vc order 3", 64'(vc_grant_o[2:0]), 64'b100);
        step("R5"); check("R5", "vc order wrap", 64'(vc_grant_o[2:0]), 64'b001);

        // R6: four inputs compete for output 2 in rotation.
        clear_all();
        for (int i = 0; i < P; i++) set_vc(i, 0, 2, 1'b1, 1'b1);
        for (int n = 0; n < 5; n++) begin
            step("R6");
            check("R6", "out2 rotation", 64'(out_grant_o[8 +: 4]), 64'(4'b0001 << (n % P)));
        end

        // R5: a losing choice keeps its pointer.
        clear_all();
        set_vc(1, 0, 3, 1'b1, 1'b1);
        set_vc(1, 1, 3, 1'b1, 1'b1);
        set_vc(0, 0, 3, 1'b1, 1'b1);
        step("R5"); check("R5", "input1 loses", 64'(vc_grant_o[5:3]), 64'b000);
        step("R5"); check("R5", "input1 keeps VC1", 64'(vc_grant_o[5:3]), 64'b010);
        step("R5"); check("R5", "input1 loses again", 64'(vc_grant_o[5:3]), 64'b000);
        step("R5"); check("R5", "input1 then VC0", 64'(vc_grant_o[5:3]), 64'b001);

        // R7/R8: packet lock on output 0 by input 0 VC1.
        clear_all();
        set_vc(0, 1, 0, 1'b1, 1'b0);
        set_vc(1, 0, 0, 1'b1, 1'b1);
        step("R7"); check("R7", "head takes out0", 64'(out_grant_o[3:0]), 64'b0001);
        set_vc(0, 1, 0, 1'b0, 1'b0);
        step("R7"); check("R7", "body holds out0", 64'(out_grant_o[3:0]), 64'b0001);
        set_vc(2, 2, 0, 1'b1, 1'b1);
        set_vc(0, 0, 0, 1'b1, 1'b1);
        step("R7"); check("R7", "owner VC only", 64'(vc_grant_o[2:0]), 64'b010);
        check("R7", "others wait", 64'(out_grant_o[3:0]), 64'b0001);
        req_valid_i[0] = 1'b0;
        set_vc(0, 1, 0, 1'b0, 1'b1);
        step("R8"); check("R8", "tail granted", 64'(out_grant_o[3:0]), 64'b0001);
        req_valid_i[1] = 1'b0;
        step("R8"); check("R8", "released to input1", 64'(out_grant_o[3:0]), 64'b0010);
        req_valid_i[3] = 1'b0;
        step("R7"); check("R7", "pointer kept then input2", 64'(out_grant_o[3:0]), 64'b0100);

        // R8: single-flit packets leave output 1 unlocked.
        clear_all();
        set_vc(3, 2, 1, 1'b1, 1'b1);
        set_vc(2, 0, 1, 1'b1, 1'b1);
        step("R8"); check("R8", "single flit A", 64'(out_grant_o[4 +: 4]), 64'b0100);
        step("R8"); check("R8", "single flit B", 64'(out_grant_o[4 +: 4]), 64'b1000);

        // R9: body flits on a free output are ignored.
        clear_all();
        set_vc(2, 1, 3, 1'b0, 1'b0);
        step("R9"); check("R9", "body on free output", 64'(out_grant_o), 64'd0);
        set_vc(2, 1, 3, 1'b0, 1'b1);
        step("R9"); check("R9", "tail on free output", 64'(vc_grant_o), 64'd0);

        // R3/R1/R2: long pseudo-random sweep against the model.
        for (int n = 0; n < 4000; n++) begin
            for (int b = 0; b < NPV; b++) begin
                logic [31:0] r;
                r = $urandom;
                req_valid_i[b] = r[0] | r[1];
                req_dest_i[b*PW +: PW] = r[3:2];
                req_head_i[b] = r[4];
                req_tail_i[b] = r[5] & r[6];
            end
            step("R3");
            for (int i = 0; i < P; i++)
                check("R1", "vc grants per input", 64'($countones(vc_grant_o[i*V +: V]) <= 1), 64'd1);
            for (int o = 0; o < P; o++)
                check("R2", "inputs per output", 64'($countones(out_grant_o[o*P +: P]) <= 1), 64'd1);
        end

        // R10: reset mid-run clears locks and pointers.
        clear_all();
        rst_n = 1'b0;
        step("R10");
        model_reset();
        rst_n = 1'b1;
        for (int v = 0; v < V; v++) set_vc(3, v, 0, 1'b1, 1'b1);
        step("R10"); check("R10", "pointer back to VC0", 64'(vc_grant_o[11:9]), 64'b001);

        finish_run();
    end

endmodule